// File: doc/BRIEF.md
# Glitch-Free System Clock Prescaler

This block turns a fast main clock into a slower system-clock enable. It divides by a power of two between 1 and 256. Software chooses the ratio by writing a 4-bit code into a small control register. That write only lands while an external protection window is open. Codes outside the supported range leave the register unchanged. The output is a one-cycle enable pulse, `clk_en`, that fires once per divided period. Logic in the system clock domain runs on the main clock and is gated by `clk_en`.

The ratio may be changed while the block is running. The new code is first held in the register, and the divider keeps its current ratio. A two-state controller applies the new code only at the terminal count of the running period. Because of this, the period in progress always completes at its full old length. The next period is already at the new length, so no interval between pulses is shorter than both the old and the new period. The divider counter runs on the undivided main clock.

Controller states and transitions:
- STEADY: the active ratio equals the register field.
- STEADY to PENDING ("request"): the field differs from the active ratio.
- PENDING to STEADY ("apply"): the terminal count is reached. The active ratio loads the field and the counter restarts.
- PENDING to STEADY ("cancel"): the field is written back to the active ratio before any terminal count.

Top module: `sysclk_prescaler`

## Requirements
- R1: After an asynchronous reset the field holds code 3 (divide by 8) and reads back as 0x03. The first `clk_en` pulse is the eighth main-clock cycle, counting the cycle in which reset is released.
- R2: With active code k in 0..8, `clk_en` pulses once every 2^k main-clock cycles. Code 0 gives a pulse on every cycle.
- R3: A write changes the field only when `wr_en`, `unlock` and `wr_addr == 0x36` are all true. The field is `wr_data[3:0]`, and `wr_data[7:4]` is ignored.
- R4: A write carrying a code of 9 to 15 is ignored, and the previous code stays in both the field and the active ratio.
- R5: A read with `rd_addr == 0x36` returns the 4-bit field in bits 3:0 with zeros in bits 7:4. Any other read address returns 0x00.
- R6: A ratio change takes effect only at a terminal count of the running ratio. The period in progress completes at its old length, so no interval is shorter than the shorter of the two periods.
- R7: A write accepted in cycle w first enters PENDING in cycle w+1. The first terminal count at or after cycle w+1 applies the new code, and every later period has the new length.
- R8: If the field is rewritten to the active code while PENDING, the controller cancels back to STEADY and the period length never changes.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Undivided main clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| wr_en | input | 1 | Register write strobe |
| wr_addr | input | 6 | Register write address |
| wr_data | input | 8 | Register write data, code in bits 3:0 |
| unlock | input | 1 | Protection window open, enables writes |
| rd_addr | input | 6 | Register read address |
| rd_data | output | 8 | Readback data |
| clk_en | output | 1 | One-cycle enable per divided period |

## Verification
Every legal code is visited in a scrambled order, so each step changes the ratio both up and down. A wrong shift or terminal value then shows up as a wrong pulse spacing. Writes are placed in the middle of long periods, moving both 256 to 1 and 1 to 256. These separate a switch taken at the terminal count from one taken at the write, which would leave a truncated interval. A write followed by its own undo tells the cancel path apart from an apply at the next terminal count. Locked writes, writes to the wrong address and reserved codes are each followed by period and readback checks, which show that nothing moved.

// File: rtl/psc_pkg.sv
package psc_pkg;

    // Ratio controller states
    typedef enum logic [0:0] {
        ST_STEADY  = 1'b0,
        ST_PENDING = 1'b1
    } psc_state_t;

endpackage

// File: rtl/psc_select_reg.sv
module psc_select_reg #(
    parameter int          SEL_W      = 4,
    parameter int          DATA_W     = 8,
    parameter int          ADDR_W     = 6,
    parameter int          MAX_CODE   = 8,
    parameter int          RESET_CODE = 3,
    parameter logic [5:0]  REG_ADDR   = 6'h36
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wr_en,
    input  logic [ADDR_W-1:0] wr_addr,
    input  logic [SEL_W-1:0]  wr_field,
    input  logic              unlock,
    input  logic [ADDR_W-1:0] rd_addr,
    output logic [DATA_W-1:0] rd_data,
    output logic [SEL_W-1:0]  sel_field
);

    localparam logic [SEL_W-1:0]  MAX_SEL   = SEL_W'(MAX_CODE);
    localparam logic [SEL_W-1:0]  RST_SEL   = SEL_W'(RESET_CODE);
    localparam logic [ADDR_W-1:0] MY_ADDR   = ADDR_W'(REG_ADDR);
    localparam int                PAD_W     = DATA_W - SEL_W;

    logic [SEL_W-1:0] sel_q;
    logic             hit_wr;
    logic             code_ok;

    // A write lands only inside the window, at our address, with a legal code
    always_comb begin
        hit_wr  = wr_en && unlock && (wr_addr == MY_ADDR);
        code_ok = (wr_field <= MAX_SEL);
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            sel_q <= RST_SEL;
        end else if (hit_wr && code_ok) begin
            sel_q <= wr_field;
        end
    end

    // Upper readback bits are always zero
    always_comb begin
        if (rd_addr == MY_ADDR) begin
            rd_data = {{PAD_W{1'b0}}, sel_q};
        end else begin
            rd_data = '0;
        end
    end

    assign sel_field = sel_q;

endmodule

// File: rtl/psc_counter.sv
module psc_counter #(
    parameter int SEL_W = 4,
    parameter int CNT_W = 8
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [SEL_W-1:0] act_sel,
    output logic [CNT_W-1:0] cnt,
    output logic             tick
);

    logic [CNT_W:0]   span;
    logic [CNT_W-1:0] last;
    logic [CNT_W-1:0] cnt_q;

    // Terminal value for a divide-by-2^act_sel period
    always_comb begin
        span = {{CNT_W{1'b0}}, 1'b1} << act_sel;
        last = CNT_W'(span - 1'b1);
        tick = (cnt_q == last);
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            cnt_q <= '0;
        end else if (tick) begin
            cnt_q <= '0;
        end else begin
            cnt_q <= cnt_q + 1'b1;
        end
    end

    assign cnt = cnt_q;

endmodule

// File: rtl/psc_ratio_fsm.sv
module psc_ratio_fsm
    import psc_pkg::*;
#(
    parameter int SEL_W      = 4,
    parameter int RESET_CODE = 3
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [SEL_W-1:0] sel_field,
    input  logic             tick,
    output logic [SEL_W-1:0] act_sel,
    output logic             apply
);

    localparam logic [SEL_W-1:0] RST_SEL = SEL_W'(RESET_CODE);

    psc_state_t       state_q;
    psc_state_t       state_d;
    logic [SEL_W-1:0] act_q;

    // Next-state logic: request, apply, cancel
    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_STEADY: begin
                if (sel_field != act_q) begin
                    state_d = ST_PENDING;
                end
            end
            ST_PENDING: begin
                if (tick || (sel_field == act_q)) begin
                    state_d = ST_STEADY;
                end
            end
        endcase
    end

    // State register and active ratio
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state_q <= ST_STEADY;
            act_q   <= RST_SEL;
        end else begin
            state_q <= state_d;
            if (apply) begin
                act_q <= sel_field;
            end
        end
    end

    // Output logic: switch only at a terminal count while pending
    always_comb begin
        apply = 1'b0;
        unique case (state_q)
            ST_STEADY:  apply = 1'b0;
            ST_PENDING: apply = tick;
        endcase
    end

    assign act_sel = act_q;

endmodule

// File: rtl/sysclk_prescaler.sv
module sysclk_prescaler #(
    parameter int          SEL_W      = 4,
    parameter int          DATA_W     = 8,
    parameter int          ADDR_W     = 6,
    parameter int          MAX_CODE   = 8,
    parameter int          RESET_CODE = 3,
    parameter logic [5:0]  REG_ADDR   = 6'h36
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wr_en,
    input  logic [ADDR_W-1:0] wr_addr,
    input  logic [DATA_W-1:0] wr_data,
    input  logic              unlock,
    input  logic [ADDR_W-1:0] rd_addr,
    output logic [DATA_W-1:0] rd_data,
    output logic              clk_en
);

    localparam int CNT_W = (MAX_CODE > 0) ? MAX_CODE : 1;

    logic [SEL_W-1:0] sel_q;
    logic [SEL_W-1:0] act_q;
    logic [CNT_W-1:0] cnt_q;
    logic             tc;
    logic             apply;
    logic             unused_hi;

    // Reserved write bits carry no meaning
    assign unused_hi = ^wr_data[DATA_W-1:SEL_W];

    psc_select_reg #(
        .SEL_W      (SEL_W),
        .DATA_W     (DATA_W),
        .ADDR_W     (ADDR_W),
        .MAX_CODE   (MAX_CODE),
        .RESET_CODE (RESET_CODE),
        .REG_ADDR   (REG_ADDR)
    ) u_sel (
        .clk       (clk),
        .rst_n     (rst_n),
        .wr_en     (wr_en),
        .wr_addr   (wr_addr),
        .wr_field  (wr_data[SEL_W-1:0]),
        .unlock    (unlock),
        .rd_addr   (rd_addr),
        .rd_data   (rd_data),
        .sel_field (sel_q)
    );

    psc_ratio_fsm #(
        .SEL_W      (SEL_W),
        .RESET_CODE (RESET_CODE)
    ) u_fsm (
        .clk       (clk),
        .rst_n     (rst_n),
        .sel_field (sel_q),
        .tick      (tc),
        .act_sel   (act_q),
        .apply     (apply)
    );

    psc_counter #(
        .SEL_W (SEL_W),
        .CNT_W (CNT_W)
    ) u_cnt (
        .clk     (clk),
        .rst_n   (rst_n),
        .act_sel (act_q),
        .cnt     (cnt_q),
        .tick    (tc)
    );

    assign clk_en = tc;

endmodule

// File: rtl/psc_checker.sv
module psc_checker #(
    parameter int          SEL_W    = 4,
    parameter int          DATA_W   = 8,
    parameter int          ADDR_W   = 6,
    parameter int          MAX_CODE = 8,
    parameter int          CNT_W    = 8,
    parameter logic [5:0]  REG_ADDR = 6'h36
) (
    input logic                    clk,
    input logic                    rst_n,
    input logic                    wr_en,
    input logic [ADDR_W-1:0]       wr_addr,
    input logic [SEL_W-1:0]        wr_field,
    input logic                    unlock,
    input logic [DATA_W-SEL_W-1:0] rd_hi,
    input logic                    clk_en,
    input logic [SEL_W-1:0]        sel_q,
    input logic [SEL_W-1:0]        act_q,
    input logic [CNT_W-1:0]        cnt_q
);

    localparam logic [SEL_W-1:0]  MAX_SEL = SEL_W'(MAX_CODE);
    localparam logic [ADDR_W-1:0] MY_ADDR = ADDR_W'(REG_ADDR);

    a_r3_write_loads: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en && unlock && (wr_addr == MY_ADDR) && (wr_field <= MAX_SEL))
        |=> (sel_q == $past(wr_field)));

    a_r3_locked_ignored: assert property (@(posedge clk) disable iff (!rst_n)
        (!wr_en || !unlock || (wr_addr != MY_ADDR)) |=> $stable(sel_q));

    a_r4_reserved_ignored: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_field > MAX_SEL) |=> $stable(sel_q));

    a_r4_field_legal: assert property (@(posedge clk) disable iff (!rst_n)
        (sel_q <= MAX_SEL) && (act_q <= MAX_SEL));

    a_r5_upper_zero: assert property (@(posedge clk) disable iff (!rst_n)
        rd_hi == '0);

    a_r6_switch_at_tc: assert property (@(posedge clk) disable iff (!rst_n)
        !$stable(act_q) |-> $past(clk_en));

    a_r2_restart_after_tc: assert property (@(posedge clk) disable iff (!rst_n)
        clk_en |=> (cnt_q == '0));

endmodule

bind sysclk_prescaler psc_checker #(
    .SEL_W    (SEL_W),
    .DATA_W   (DATA_W),
    .ADDR_W   (ADDR_W),
    .MAX_CODE (MAX_CODE),
    .CNT_W    (CNT_W),
    .REG_ADDR (REG_ADDR)
) u_psc_checker (
    .clk      (clk),
    .rst_n    (rst_n),
    .wr_en    (wr_en),
    .wr_addr  (wr_addr),
    .wr_field (wr_data[SEL_W-1:0]),
    .unlock   (unlock),
    .rd_hi    (rd_data[DATA_W-1:SEL_W]),
    .clk_en   (clk_en),
    .sel_q    (sel_q),
    .act_q    (act_q),
    .cnt_q    (cnt_q)
);

// File: tb/sysclk_prescaler_bench.sv
module sysclk_prescaler_bench;

    localparam int CLK_PERIOD = 10;
    localparam int NVEC       = 9;
    localparam logic [5:0] RADDR = 6'h36;

    // Stimulus table: code written, expected pulse spacing
    localparam logic [3:0] VEC_CODE [NVEC] = '{4'd0, 4'd4, 4'd1, 4'd8, 4'd2,
                                               4'd5, 4'd7, 4'd6, 4'd3};
    localparam int         VEC_DIV  [NVEC] = '{1, 16, 2, 256, 4, 32, 128, 64, 8};

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       wr_en = 1'b0;
    logic [5:0] wr_addr = '0;
    logic [7:0] wr_data = '0;
    logic       unlock = 1'b0;
    logic [5:0] rd_addr = RADDR;
    logic [7:0] rd_data;
    logic       clk_en;

    int n_checks = 0;
    int n_err    = 0;
    int cyc      = 0;
    int last_tc  = 0;
    int gap      = 0;
    int tc_cnt   = 0;

    sysclk_prescaler u_sysclk_prescaler (
        .clk     (clk),
        .rst_n   (rst_n),
        .wr_en   (wr_en),
        .wr_addr (wr_addr),
        .wr_data (wr_data),
        .unlock  (unlock),
        .rd_addr (rd_addr),
        .rd_data (rd_data),
        .clk_en  (clk_en)
    );

    always #(CLK_PERIOD/2) clk = ~clk;

    // Pulse monitor, sampled away from the active edge
    always @(negedge clk) begin
        cyc = cyc + 1;
        if (rst_n && clk_en) begin
            gap     = cyc - last_tc;
            last_tc = cyc;
            tc_cnt  = tc_cnt + 1;
        end
    end

    task automatic check(input string tag, input int act, input int exp);
        n_checks++;
        if (act != exp) begin
            n_err++;
            $display("FAIL %s actual %0d expected %0d", tag, act, exp);
        end
    endtask

    task automatic step();
        @(negedge clk);
        #1;
    endtask

    task automatic wait_tc();
        int start;
        start = tc_cnt;
        do step(); while (tc_cnt == start);
    endtask

    task automatic write_reg(input logic [5:0] a, input logic [7:0] d, input logic key);
        wr_en   = 1'b1;
        wr_addr = a;
        wr_data = d;
        unlock  = key;
        step();
        wr_en   = 1'b0;
        unlock  = 1'b0;
        wr_data = '0;
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        n_err++;
        $display("FAIL watchdog expired");
        $display("CHECKS %0d ERRORS %0d", n_checks, n_err);
        $finish;
    end

    initial begin
        int rel;
        repeat (3) step();
        // R1: reset state
        check("R1 reset readback", int'(rd_data), 3);
        rst_n = 1'b1;
        rel = cyc;
        wait_tc();
        check("R1 first pulse after release", cyc - rel, 7);
        wait_tc();
        check("R1 reset ratio period", gap, 8);

        // R2/R5: table walk over all legal codes, upper data bits set (R3)
        for (int i = 0; i < NVEC; i++) begin
            write_reg(RADDR, {4'hA, VEC_CODE[i]}, 1'b1);
            repeat (3) wait_tc();
            check("R2 period after switch", gap, VEC_DIV[i]);
            wait_tc();
            check("R2 period steady", gap, VEC_DIV[i]);
            check("R5 readback field", int'(rd_data), int'(VEC_CODE[i]));
        end

        // R3: locked write ignored
        write_reg(RADDR, 8'h00, 1'b0);
        repeat (3) wait_tc();
        check("R3 locked write period", gap, 8);
        check("R3 locked write readback", int'(rd_data), 3);

        // R3: wrong address ignored
        write_reg(6'h35, 8'h00, 1'b1);
        repeat (3) wait_tc();
        check("R3 wrong address period", gap, 8);
        check("R3 wrong address readback", int'(rd_data), 3);

        // R4: reserved codes ignored
        write_reg(RADDR, 8'h0C, 1'b1);
        repeat (3) wait_tc();
        check("R4 reserved code period", gap, 8);
        check("R4 reserved code readback", int'(rd_data), 3);
        write_reg(RADDR, 8'h09, 1'b1);
        check("R4 code 9 readback", int'(rd_data), 3);

        // R5: other read address
        rd_addr = 6'h00;
        #1;
        check("R5 other address reads zero", int'(rd_data), 0);
        rd_addr = RADDR;

        // R6: 256 -> 1 mid-period keeps old period whole
        write_reg(RADDR, 8'h08, 1'b1);
        repeat (3) wait_tc();
        repeat (50) step();
        write_reg(RADDR, 8'h00, 1'b1);
        wait_tc();
        check("R6 old period completes", gap, 256);
        wait_tc();
        check("R7 new period after apply", gap, 1);

        // R7: 1 -> 256, one more unit pulse then the long period
        write_reg(RADDR, 8'h08, 1'b1);
        wait_tc();
        check("R7 pulse before apply", gap, 1);
        wait_tc();
        check("R6 no short interval upward", gap, 256);

        // R8: request then undo before terminal count
        repeat (40) step();
        write_reg(RADDR, 8'h00, 1'b1);
        repeat (5) step();
        write_reg(RADDR, 8'h08, 1'b1);
        wait_tc();
        check("R8 cancel keeps period", gap, 256);
        wait_tc();
        check("R8 cancel keeps next period", gap, 256);
        check("R8 cancel readback", int'(rd_data), 8);

        // R1: asynchronous reset in the middle of a period
        repeat (20) step();
        rst_n = 1'b0;
        #1;
        check("R1 async reset readback", int'(rd_data), 3);
        step();
        rst_n = 1'b1;
        rel = cyc;
        wait_tc();
        check("R1 first pulse after second reset", cyc - rel, 7);

        $display("CHECKS %0d ERRORS %0d", n_checks, n_err);
        $finish;
    end

endmodule